// File: doc/BRIEF.md
# Two-Word-Burst Split-Port SRAM Command Controller

This controller sits between a core-side request interface and a bank of pipelined, double-data-rate static RAMs. Those RAMs read on one unidirectional port and write on another, and every access moves exactly two words. The core offers writes and reads on two independent valid/ready channels. Each cycle the controller picks at most one of them and turns it into a command on one shared single-rate address bus. The command also sets a shared read/write select and pulls low the load strobe of the one bank that the upper address bits decode.

A write carries both burst words and their byte enables in a single transfer. The first word goes out as the rising-edge beat and the second as the falling-edge beat, each with its own active-low byte-write mask. A read carries a tag. The tag rides a fixed-depth latency pipeline and comes back with the two returned words, in the order the reads were issued. Reads and writes use separate data paths, so a write and a read can be issued in consecutive cycles with no idle cycle between them.

Top module: `sio_b2_ctrl`

## Requirements
- R1: While `rst_n` is low, `wr_ready` and `rd_ready` are low, every bit of `mem_ld_n` is high, and both byte-write masks are all ones.
- R2: A write accepted in cycle T-1 appears in cycle T with these values: `mem_rw` = 0 and `mem_addr` equal to the low AW address bits. `mem_d_rise`/`mem_d_fall` carry the first and second words. `mem_bw_n_rise`/`mem_bw_n_fall` carry the inverted enables of the first and second words.
- R3: A read accepted in cycle T-1 appears in cycle T with `mem_rw` = 1, `mem_addr` equal to the low AW address bits, and both byte-write masks all ones.
- R4: In a cycle that carries no command, every load strobe is high and both byte-write masks are all ones.
- R5: Request address bits [AW+log2(BANKS)-1:AW] select the bank. In a command cycle only `mem_ld_n[bank]` is low.
- R6: Byte-enable bit i qualifies bits [9i+8:9i] of its word. A byte whose enable is 0 keeps its stored contents.
- R7: A read whose command occupies cycle T yields `rsp_valid` = 1 in cycle T+RD_LAT. In that cycle `rsp_tag` holds the request tag, and `rsp_data0`/`rsp_data1` hold the words on `mem_q_rise`/`mem_q_fall` in that same cycle.
- R8: Reads accepted in consecutive cycles return in consecutive cycles, in issue order, each with its own tag.
- R9: While both channels stay valid, grants alternate between write and read.
- R10: At most one request is accepted per cycle.
- R11: A read can be accepted in the cycle right after a write to the same address, and it returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write request accepted this cycle if valid |
| wr_addr | input | AW+log2(BANKS) | Write burst address, bank in the top bits |
| wr_data0 | input | DW | First write word (rising beat) |
| wr_data1 | input | DW | Second write word (falling beat) |
| wr_be0 | input | DW/9 | Byte enables of the first word, active high |
| wr_be1 | input | DW/9 | Byte enables of the second word, active high |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request accepted this cycle if valid |
| rd_addr | input | AW+log2(BANKS) | Read burst address, bank in the top bits |
| rd_tag | input | TAGW | Tag returned with the read data |
| rsp_valid | output | 1 | Read burst returned this cycle |
| rsp_tag | output | TAGW | Tag of the returned burst |
| rsp_data0 | output | DW | First returned word |
| rsp_data1 | output | DW | Second returned word |
| mem_addr | output | AW | Shared memory address bus |
| mem_rw | output | 1 | Shared select: 1 read, 0 write |
| mem_ld_n | output | BANKS | Per-bank load strobes, active low |
| mem_d_rise | output | DW | Write word for the rising beat |
| mem_d_fall | output | DW | Write word for the falling beat |
| mem_bw_n_rise | output | DW/9 | Byte-write mask of the rising beat, active low |
| mem_bw_n_fall | output | DW/9 | Byte-write mask of the falling beat, active low |
| mem_q_rise | input | DW | Read word from the rising beat |
| mem_q_fall | input | DW | Read word from the falling beat |

## Verification
The bench builds the controller with four banks, a 6-bit bank-local address, 18-bit words and a read latency of 3. With four banks the bench can drive every strobe position of the bank decode, and not only the two that the default configuration has. With a latency of 3, up to three reads are in flight at once, so the bench can check that a stream of them keeps its order and its tags. The 18-bit width gives two 9-bit bytes, so the bench can mix enabled and disabled bytes in each beat of one burst.

// File: rtl/sio_b2_ctrl.sv
module sio_b2_ctrl #(
  parameter int AW     = 19,
  parameter int BANKS  = 2,
  parameter int DW     = 18,
  parameter int TAGW   = 4,
  parameter int RD_LAT = 2,
  localparam int NBY   = DW / 9,
  localparam int BKW   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int UAW   = AW + BKW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [UAW-1:0]  wr_addr,
  input  logic [DW-1:0]   wr_data0,
  input  logic [DW-1:0]   wr_data1,
  input  logic [NBY-1:0]  wr_be0,
  input  logic [NBY-1:0]  wr_be1,
  input  logic            rd_valid,
  output logic            rd_ready,
  input  logic [UAW-1:0]  rd_addr,
  input  logic [TAGW-1:0] rd_tag,
  output logic            rsp_valid,
  output logic [TAGW-1:0] rsp_tag,
  output logic [DW-1:0]   rsp_data0,
  output logic [DW-1:0]   rsp_data1,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rw,
  output logic [BANKS-1:0] mem_ld_n,
  output logic [DW-1:0]   mem_d_rise,
  output logic [DW-1:0]   mem_d_fall,
  output logic [NBY-1:0]  mem_bw_n_rise,
  output logic [NBY-1:0]  mem_bw_n_fall,
  input  logic [DW-1:0]   mem_q_rise,
  input  logic [DW-1:0]   mem_q_fall
);

  logic           turn_wr;
  logic           wr_go, rd_go, any_go;
  logic [UAW-1:0] sel_addr;
  logic [BKW-1:0] sel_bank;

  assign wr_ready = rst_n && (!rd_valid || turn_wr);
  assign rd_ready = rst_n && (!wr_valid || !turn_wr);
  assign wr_go    = wr_valid && wr_ready;
  assign rd_go    = rd_valid && rd_ready;
  assign any_go   = wr_go || rd_go;
  assign sel_addr = wr_go ? wr_addr : rd_addr;
  assign sel_bank = sel_addr[UAW-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n)     turn_wr <= 1'b0;
    else if (wr_go) turn_wr <= 1'b0;
    else if (rd_go) turn_wr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr      <= '0;
      mem_rw        <= 1'b1;
      mem_d_rise    <= '0;
      mem_d_fall    <= '0;
      mem_bw_n_rise <= '1;
      mem_bw_n_fall <= '1;
    end else begin
      mem_bw_n_rise <= '1;
      mem_bw_n_fall <= '1;
      if (any_go) begin
        mem_addr <= sel_addr[AW-1:0];
        mem_rw   <= !wr_go;
      end
      if (wr_go) begin
        mem_d_rise    <= wr_data0;
        mem_d_fall    <= wr_data1;
        mem_bw_n_rise <= ~wr_be0;
        mem_bw_n_fall <= ~wr_be1;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_ld
    always_ff @(posedge clk) begin
      if (!rst_n) mem_ld_n[b] <= 1'b1;
      else        mem_ld_n[b] <= !(any_go && (sel_bank == BKW'(b)));
    end
  end

  logic [RD_LAT:0] pv;
  logic [TAGW-1:0] pt [RD_LAT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv[0] <= 1'b0;
      pt[0] <= '0;
    end else begin
      pv[0] <= rd_go;
      pt[0] <= rd_tag;
    end
  end

  for (genvar s = 1; s <= RD_LAT; s++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pv[s] <= 1'b0;
        pt[s] <= '0;
      end else begin
        pv[s] <= pv[s-1];
        pt[s] <= pt[s-1];
      end
    end
  end

  assign rsp_valid = pv[RD_LAT];
  assign rsp_tag   = pt[RD_LAT];
  assign rsp_data0 = mem_q_rise;
  assign rsp_data1 = mem_q_fall;

endmodule

module sio_b2_ctrl_chk #(
  parameter int AW     = 19,
  parameter int BANKS  = 2,
  parameter int DW     = 18,
  parameter int TAGW   = 4,
  parameter int RD_LAT = 2,
  localparam int NBY   = DW / 9,
  localparam int BKW   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int UAW   = AW + BKW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [UAW-1:0]  wr_addr,
  input logic [DW-1:0]   wr_data0,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            rsp_valid,
  input logic            mem_rw,
  input logic [BANKS-1:0] mem_ld_n,
  input logic [DW-1:0]   mem_d_rise,
  input logic [NBY-1:0]  mem_bw_n_rise,
  input logic [NBY-1:0]  mem_bw_n_fall
);

  logic wgo, rgo;
  assign wgo = wr_valid && wr_ready;
  assign rgo = rd_valid && rd_ready;

  logic [7:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + {7'd0, rgo} - {7'd0, rsp_valid};
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!wr_ready && !rd_ready);
    end
  end

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wgo && rgo));

  // R2
  write_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wgo |=> (!mem_rw && (mem_ld_n != '1) && (mem_d_rise == $past(wr_data0))));

  // R3
  read_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgo |=> (mem_rw && (mem_ld_n != '1) && (&mem_bw_n_rise) && (&mem_bw_n_fall)));

  // R4
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wgo && !rgo) |=> ((&mem_ld_n) && (&mem_bw_n_rise) && (&mem_bw_n_fall)));

  // R5
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ld_n));

  // R9
  alt_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wgo |=> (!rd_valid || rd_ready));

  // R9
  alt_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgo |=> (!wr_valid || wr_ready));

  // R7
  rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (inflight != 8'd0));

  // R8
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(RD_LAT + 1));

endmodule

bind sio_b2_ctrl sio_b2_ctrl_chk #(
  .AW(AW), .BANKS(BANKS), .DW(DW), .TAGW(TAGW), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data0(wr_data0),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
  .mem_rw(mem_rw), .mem_ld_n(mem_ld_n), .mem_d_rise(mem_d_rise),
  .mem_bw_n_rise(mem_bw_n_rise), .mem_bw_n_fall(mem_bw_n_fall)
);

// File: tb/test_sio_b2_ctrl.sv
module test_sio_b2_ctrl;
  localparam int AW = 6, BANKS = 4, DW = 18, TAGW = 4, RD_LAT = 3;
  localparam int NBY = DW / 9, BKW = 2, UAW = AW + BKW, NLOC = 1 << UAW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic wr_ready, rd_ready;
  logic [UAW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data0 = '0, wr_data1 = '0;
  logic [NBY-1:0] wr_be0 = '0, wr_be1 = '0;
  logic [TAGW-1:0] rd_tag = '0;
  logic rsp_valid;
  logic [TAGW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data0, rsp_data1;
  logic [AW-1:0] mem_addr;
  logic mem_rw;
  logic [BANKS-1:0] mem_ld_n;
  logic [DW-1:0] mem_d_rise, mem_d_fall, mem_q_rise, mem_q_fall;
  logic [NBY-1:0] mem_bw_n_rise, mem_bw_n_fall;

  always #4 clk = ~clk;

  sio_b2_ctrl #(.AW(AW), .BANKS(BANKS), .DW(DW), .TAGW(TAGW), .RD_LAT(RD_LAT)) i_sio_b2_ctrl (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_data0, .wr_data1, .wr_be0, .wr_be1,
    .rd_valid, .rd_ready, .rd_addr, .rd_tag, .rsp_valid, .rsp_tag, .rsp_data0, .rsp_data1,
    .mem_addr, .mem_rw, .mem_ld_n, .mem_d_rise, .mem_d_fall, .mem_bw_n_rise, .mem_bw_n_fall,
    .mem_q_rise, .mem_q_fall);

  // SRAM model
  logic [DW-1:0] ram0 [NLOC];
  logic [DW-1:0] ram1 [NLOC];
  logic [DW-1:0] qd0 [RD_LAT];
  logic [DW-1:0] qd1 [RD_LAT];
  assign mem_q_rise = qd0[RD_LAT-1];
  assign mem_q_fall = qd1[RD_LAT-1];

  always @(posedge clk) begin
    int bk;
    bk = -1;
    for (int b = 0; b < BANKS; b++) if (!mem_ld_n[b]) bk = b;
    qd0[0] <= '0;
    qd1[0] <= '0;
    if (rst_n && bk >= 0) begin
      if (mem_rw) begin
        qd0[0] <= ram0[{bk[BKW-1:0], mem_addr}];
        qd1[0] <= ram1[{bk[BKW-1:0], mem_addr}];
      end else begin
        for (int i = 0; i < NBY; i++) begin
          if (!mem_bw_n_rise[i]) ram0[{bk[BKW-1:0], mem_addr}][9*i +: 9] <= mem_d_rise[9*i +: 9];
          if (!mem_bw_n_fall[i]) ram1[{bk[BKW-1:0], mem_addr}][9*i +: 9] <= mem_d_fall[9*i +: 9];
        end
      end
    end
    for (int k = 1; k < RD_LAT; k++) begin
      qd0[k] <= qd0[k-1];
      qd1[k] <= qd1[k-1];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rn = 0;
  int r_cyc [64];
  logic [TAGW-1:0] r_tag [64];
  logic [DW-1:0] r_d0 [64];
  logic [DW-1:0] r_d1 [64];
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rn < 64) begin
      r_cyc[rn] = cyc; r_tag[rn] = rsp_tag; r_d0[rn] = rsp_data0; r_d1[rn] = rsp_data1;
      rn = rn + 1;
    end
  end

  logic [DW-1:0] ex0 [NLOC];
  logic [DW-1:0] ex1 [NLOC];

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NBY-1:0] en);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NBY; i++) if (en[i]) r[9*i +: 9] = nw[9*i +: 9];
    return r;
  endfunction

  function automatic logic [BANKS-1:0] strobe(input logic [UAW-1:0] a);
    return ~(BANKS'(1) << a[UAW-1:AW]);
  endfunction

  // single write; checks command outputs in the command cycle
  task automatic do_write(input logic [UAW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [NBY-1:0] b0, input logic [NBY-1:0] b1);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data0 = d0; wr_data1 = d1; wr_be0 = b0; wr_be1 = b1;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    ex0[a] = merge(ex0[a], d0, b0);
    ex1[a] = merge(ex1[a], d1, b1);
    @(negedge clk);
    wr_valid = 0;
    chk(mem_rw == 1'b0, "R2", "write rw", 64'(mem_rw), 64'(0));
    chk(mem_addr == a[AW-1:0], "R2", "write addr", 64'(mem_addr), 64'(a[AW-1:0]));
    chk(mem_d_rise == d0 && mem_d_fall == d1, "R2", "write words",
        {mem_d_rise, mem_d_fall}, {d0, d1});
    chk(mem_bw_n_rise == ~b0 && mem_bw_n_fall == ~b1, "R2", "write masks",
        64'({mem_bw_n_rise, mem_bw_n_fall}), 64'({~b0, ~b1}));
    chk(mem_ld_n == strobe(a), "R5", "write strobe", 64'(mem_ld_n), 64'(strobe(a)));
  endtask

  // single read; checks command and the response
  task automatic do_read(input logic [UAW-1:0] a, input logic [TAGW-1:0] t, input string req);
    int base, cc;
    base = rn;
    @(negedge clk);
    rd_valid = 1; rd_addr = a; rd_tag = t;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 0;
    cc = cyc;
    chk(mem_rw == 1'b1, "R3", "read rw", 64'(mem_rw), 64'(1));
    chk(mem_addr == a[AW-1:0], "R3", "read addr", 64'(mem_addr), 64'(a[AW-1:0]));
    chk(&mem_bw_n_rise && &mem_bw_n_fall, "R3", "read masks",
        64'({mem_bw_n_rise, mem_bw_n_fall}), 64'({NBY{2'b11}}));
    chk(mem_ld_n == strobe(a), "R5", "read strobe", 64'(mem_ld_n), 64'(strobe(a)));
    repeat (RD_LAT + 1) @(negedge clk);
    chk(rn == base + 1, "R7", "response count", 64'(rn - base), 64'(1));
    if (rn > base) begin
      chk(r_cyc[base] == cc + RD_LAT, "R7", "latency", 64'(r_cyc[base] - cc), 64'(RD_LAT));
      chk(r_tag[base] == t, "R7", "tag", 64'(r_tag[base]), 64'(t));
      chk(r_d0[base] == ex0[a] && r_d1[base] == ex1[a], req, "read data",
          {r_d0[base], r_d1[base]}, {ex0[a], ex1[a]});
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    wr_valid = 1; rd_valid = 1;
    #1;
    chk(!wr_ready && !rd_ready, "R1", "ready in reset", 64'({wr_ready, rd_ready}), 64'(0));
    chk(&mem_ld_n, "R1", "strobes in reset", 64'(mem_ld_n), 64'({BANKS{1'b1}}));
    chk(&mem_bw_n_rise && &mem_bw_n_fall, "R1", "masks in reset",
        64'({mem_bw_n_rise, mem_bw_n_fall}), 64'({NBY{2'b11}}));
    wr_valid = 0; rd_valid = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_write_banks;
    for (int b = 0; b < BANKS; b++) begin
      logic [UAW-1:0] a;
      a = {b[BKW-1:0], AW'(5 + b)};
      do_write(a, DW'(18'h1A5A5 + b), DW'(18'h0C3C3 + b), '1, '1);
      @(negedge clk);
      chk(&mem_ld_n && &mem_bw_n_rise && &mem_bw_n_fall, "R4", "idle after write",
          64'({mem_ld_n, mem_bw_n_rise, mem_bw_n_fall}), 64'({BANKS + 2 * NBY{1'b1}}));
    end
  endtask

  task automatic t_read_banks;
    for (int b = 0; b < BANKS; b++) do_read({b[BKW-1:0], AW'(5 + b)}, TAGW'(b + 8), "R7");
  endtask

  task automatic t_bytes;
    logic [UAW-1:0] a;
    a = {2'd2, 6'd33};
    do_write(a, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11);
    do_write(a, 18'h00000, 18'h00000, 2'b01, 2'b10);
    do_write(a, 18'h12345, 18'h12345, 2'b00, 2'b00);
    do_read(a, 4'h3, "R6");
  endtask

  task automatic t_stream;
    int base, c0;
    base = rn;
    for (int i = 0; i < 4; i++) begin
      logic [UAW-1:0] a;
      a = {i[BKW-1:0], AW'(5 + i)};
      @(negedge clk);
      rd_valid = 1; rd_addr = a; rd_tag = TAGW'(i + 1);
    end
    @(negedge clk);
    rd_valid = 0;
    repeat (RD_LAT + 2) @(negedge clk);
    chk(rn == base + 4, "R8", "stream count", 64'(rn - base), 64'(4));
    if (rn >= base + 4) begin
      c0 = r_cyc[base];
      for (int i = 0; i < 4; i++) begin
        logic [UAW-1:0] a;
        a = {i[BKW-1:0], AW'(5 + i)};
        chk(r_tag[base + i] == TAGW'(i + 1) && r_cyc[base + i] == c0 + i, "R8", "stream order",
            64'(r_tag[base + i]), 64'(i + 1));
        chk(r_d0[base + i] == ex0[a] && r_d1[base + i] == ex1[a], "R8", "stream data",
            {r_d0[base + i], r_d1[base + i]}, {ex0[a], ex1[a]});
      end
    end
  endtask

  task automatic t_contend;
    int wi, ri, last, base, guard;
    bit wf, rf;
    wi = 0; ri = 0; last = -1; guard = 0;
    base = rn;
    while ((wi < 3 || ri < 3) && guard < 20) begin
      @(negedge clk);
      guard++;
      wr_valid = (wi < 3); rd_valid = (ri < 3);
      wr_addr = {2'd1, AW'(40 + wi)}; wr_data0 = DW'(18'h2A000 + wi); wr_data1 = DW'(18'h05000 + wi);
      wr_be0 = '1; wr_be1 = '1;
      rd_addr = {2'd3, AW'(8)}; rd_tag = TAGW'(12 + ri);
      #1;
      wf = wr_valid && wr_ready; rf = rd_valid && rd_ready;
      chk(!(wf && rf), "R10", "double grant", 64'({wf, rf}), 64'(0));
      if (wr_valid && rd_valid) begin
        if (last >= 0)
          chk(int'(wf) != last, "R9", "alternation", 64'(wf), 64'(last == 0));
        last = int'(wf);
      end
      if (wf) begin
        ex0[wr_addr] = wr_data0; ex1[wr_addr] = wr_data1;
        wi++;
      end
      if (rf) ri++;
    end
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    repeat (RD_LAT + 2) @(negedge clk);
    chk(rn == base + 3, "R9", "reads served", 64'(rn - base), 64'(3));
    for (int i = 0; i < 3; i++) do_read({2'd1, AW'(40 + i)}, TAGW'(i), "R9");
  endtask

  task automatic t_turn;
    int base, wc, rc;
    logic [UAW-1:0] a;
    a = {2'd0, 6'd63};
    base = rn;
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data0 = 18'h0BEEF; wr_data1 = 18'h3CAFE; wr_be0 = '1; wr_be1 = '1;
    #1;
    chk(wr_ready, "R11", "write ready", 64'(wr_ready), 64'(1));
    ex0[a] = 18'h0BEEF; ex1[a] = 18'h3CAFE;
    @(negedge clk);
    wc = cyc;
    wr_valid = 0; rd_valid = 1; rd_addr = a; rd_tag = 4'h9;
    #1;
    chk(rd_ready, "R11", "read ready after write", 64'(rd_ready), 64'(1));
    @(negedge clk);
    rc = cyc;
    rd_valid = 0;
    chk(rc == wc + 1 && mem_rw, "R11", "back-to-back command", 64'(rc - wc), 64'(1));
    repeat (RD_LAT + 1) @(negedge clk);
    chk(rn == base + 1, "R11", "turn response", 64'(rn - base), 64'(1));
    if (rn > base)
      chk(r_d0[base] == ex0[a] && r_d1[base] == ex1[a], "R11", "fresh data",
          {r_d0[base], r_d1[base]}, {ex0[a], ex1[a]});
  endtask

  initial begin
    for (int i = 0; i < NLOC; i++) begin
      ram0[i] = '0; ram1[i] = '0; ex0[i] = '0; ex1[i] = '0;
    end
    for (int k = 0; k < RD_LAT; k++) begin qd0[k] = '0; qd1[k] = '0; end
    repeat (3) @(negedge clk);
    t_reset;
    repeat (2) @(negedge clk);
    t_write_banks;
    t_read_banks;
    t_bytes;
    t_stream;
    t_contend;
    t_turn;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule